// File: doc/BRIEF.md
# Keyed Flash Block-Write Controller

This block sits on the external-data write port of an 8-bit processor and decides, for every write, whether the byte goes to ordinary RAM or to the flash array. A routing control bit selects the destination. A write to flash takes effect only after software has stored a two-byte unlock key into the key register, and each unlock authorises exactly one flash write. Once that write is taken, the key has to be entered again.

Flash writes work in one of two ways. In single mode, each authorised byte produces a program command straight away. The command carries a one-hot byte-lane mask and a 32-bit data word in which the other lanes are 0xFF. In block mode, authorised bytes are gathered in a four-lane buffer. They must arrive at low address bits 00, 01, 10, 11 in that order, all within the same word. The block issues one program command with the whole assembled word only when the byte at 11 arrives. An erase-select bit turns an authorised write into an erase command.

Any bad key byte, or keys in the wrong order, locks out flash writes until reset. Other misuse sets a sticky error flag without locking. While a program or erase is in flight, every processor data access is held off by a wait output. Processor reads always go to RAM.

Top module: `kflash_blkwr`

## Requirements
- R1: Writing 0xA5 and then 0xF1 to the key register (reg_sel=0) arms exactly one flash write. The key-state readback at reg_sel=0 goes 0 (idle) to 1 (half) to 2 (armed), and returns to 0 once a flash-routed write is taken.
- R2: A key write of any other value, 0xF1 before 0xA5, or any key write while armed, moves the key state to 3 (locked) and sets the error flag. While locked, later keys and flash writes have no effect until reset.
- R3: With the route bit (control bit 0, reg_sel=1) clear, processor writes reach RAM (ram_we with the same address and data) and issue no flash command. With it set, writes never reach RAM.
- R4: Processor reads always drive ram_re, and xd_rdata returns ram_rdata, even when the route bit is set.
- R5: An authorised flash write with the erase bit (control bit 1) set pulses fl_erase for one cycle, with fl_addr equal to the byte address shifted right by two. It issues no program command.
- R6: With the block bit (control bit 2) clear, an authorised write pulses fl_prog once. fl_addr is the word address, fl_mask has only bit addr[1:0] set, and fl_wdata holds the byte in lane addr[1:0] (bits 8*lane+7:8*lane) and 0xFF in every other lane.
- R7: In block mode, authorised bytes at 00, 01, 10 of one word issue nothing. The byte at 11 then pulses fl_prog once, with fl_mask=1111 and fl_wdata holding byte 00 in bits 7:0 through byte 11 in bits 31:24.
- R8: In block mode, a byte at an unexpected position or in a different word discards the partial buffer, sets the error flag and issues no program command.
- R9: A flash-routed write with no completed unlock issues no command and sets the error flag (control readback bit 7). The error flag clears only on reset.
- R10: xd_wait is high from the cycle after a command is issued until fl_busy falls. While it is high, no processor write reaches RAM or flash.
- R11: After reset the key state is 0, the control bits and the error flag are 0, and xd_wait, fl_prog and fl_erase are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 key, 1 control |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Readback of the selected register |
| xd_wr | input | 1 | Processor data write request |
| xd_rd | input | 1 | Processor data read request |
| xd_addr | input | AW | Processor data byte address |
| xd_wdata | input | 8 | Processor write data |
| xd_rdata | output | 8 | Processor read data |
| xd_wait | output | 1 | Stall for processor data accesses |
| ram_we | output | 1 | RAM write enable |
| ram_re | output | 1 | RAM read enable |
| ram_addr | output | AW | RAM address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data |
| fl_prog | output | 1 | Flash program strobe, one cycle |
| fl_erase | output | 1 | Flash erase strobe, one cycle |
| fl_addr | output | AW-2 | Flash word address |
| fl_wdata | output | 32 | Flash program data word |
| fl_mask | output | 4 | Byte lanes to program |
| fl_busy | input | 1 | Flash operation in progress |

## Verification
Several properties are checked on every cycle. The locked key state never leaves that state, an armed key never survives a consumed flash write, and the error flag never drops. No command follows a cycle in which the flash was busy, a block program always carries a full lane mask, and a sequence error never coincides with a program strobe. Some behaviour only the directed scenarios can show. That covers the exact word and lane contents of single and block programs, erase addressing, routing of writes and reads between RAM and flash, and a RAM write held back for the whole busy window.

// File: rtl/kfb_pkg.sv
package kfb_pkg;
   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_HALF  = 2'd1,
      KS_ARMED = 2'd2,
      KS_LOCK  = 2'd3
   } key_st_t;

   localparam logic SEL_KEY = 1'b0;
   localparam logic SEL_CTL = 1'b1;

   localparam int CTL_ROUTE = 0;
   localparam int CTL_ERASE = 1;
   localparam int CTL_BLOCK = 2;
   localparam int CTL_ERR   = 7;
endpackage

// File: rtl/kfb_keyseq.sv
module kfb_keyseq
   import kfb_pkg::*;
#(
   parameter logic [7:0] KEY_A = 8'hA5,
   parameter logic [7:0] KEY_B = 8'hF1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       key_we,
   input  logic [7:0] key_byte,
   input  logic       use_i,
   output logic       armed_o,
   output key_st_t    state_o,
   output logic       fault_o
);
   key_st_t st_q, st_d;
   logic    fault_d;

   generate
      if (KEY_A == KEY_B) begin : g_bad_keys
         $error("kfb_keyseq: the two key bytes must differ");
      end
   endgenerate

   always_comb begin
      st_d    = st_q;
      fault_d = 1'b0;
      unique case (st_q)
         KS_IDLE: begin
            if (key_we) begin
               if (key_byte == KEY_A) st_d = KS_HALF;
               else begin
                  st_d    = KS_LOCK;
                  fault_d = 1'b1;
               end
            end
         end
         KS_HALF: begin
            if (key_we) begin
               if (key_byte == KEY_B) st_d = KS_ARMED;
               else begin
                  st_d    = KS_LOCK;
                  fault_d = 1'b1;
               end
            end else if (use_i) begin
               st_d = KS_IDLE;
            end
         end
         KS_ARMED: begin
            if (key_we) begin
               st_d    = KS_LOCK;
               fault_d = 1'b1;
            end else if (use_i) begin
               st_d = KS_IDLE;
            end
         end
         default: st_d = KS_LOCK;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= KS_IDLE;
      else        st_q <= st_d;
   end

   assign armed_o = (st_q == KS_ARMED);
   assign state_o = st_q;
   assign fault_o = fault_d;

   // R2: once locked, the key stays locked until reset
   p_lock_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
      st_q == KS_LOCK |=> st_q == KS_LOCK);

   // R1: one unlock is good for a single flash write
   p_single_use_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (use_i && st_q == KS_ARMED) |=> st_q != KS_ARMED);
endmodule

// File: rtl/kfb_blkasm.sv
module kfb_blkasm #(
   parameter int AW    = 16,
   parameter int LANES = 4,
   localparam int LW   = $clog2(LANES),
   localparam int WAW  = AW - LW,
   localparam int DW   = LANES * 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           wr_i,
   input  logic           block_i,
   input  logic [AW-1:0]  addr_i,
   input  logic [7:0]     data_i,
   output logic           prog_o,
   output logic [WAW-1:0] paddr_o,
   output logic [DW-1:0]  pdata_o,
   output logic [LANES-1:0] pmask_o,
   output logic           seq_err_o
);
   generate
      if (LANES < 2 || (1 << LW) != LANES) begin : g_bad_lanes
         $error("kfb_blkasm: LANES must be a power of two, at least 2");
      end
      if (AW <= LW) begin : g_bad_aw
         $error("kfb_blkasm: address too narrow for the lane count");
      end
   endgenerate

   logic [LW-1:0]    idx;
   logic [WAW-1:0]   wa;
   logic [LW-1:0]    exp_q;
   logic [WAW-1:0]   base_q;
   logic             in_order, last, issue, blk_ok;
   logic [DW-1:0]    nxt_data;
   logic [LANES-1:0] nxt_mask;
   logic [7:0]       lane_q [LANES];

   assign idx      = addr_i[LW-1:0];
   assign wa       = addr_i[AW-1:LW];
   assign in_order = (idx == exp_q) && ((exp_q == '0) || (wa == base_q));
   assign last     = (idx == LW'(LANES - 1));
   assign blk_ok   = wr_i && block_i && in_order;
   assign issue    = wr_i && (!block_i || (in_order && last));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                            lane_q[g] <= 8'hFF;
         else if (blk_ok && idx == LW'(g))      lane_q[g] <= data_i;
      end
      assign nxt_data[g*8 +: 8] = (idx == LW'(g)) ? data_i :
                                  (block_i ? lane_q[g] : 8'hFF);
      assign nxt_mask[g]        = block_i || (idx == LW'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         exp_q     <= '0;
         base_q    <= '0;
         prog_o    <= 1'b0;
         seq_err_o <= 1'b0;
         paddr_o   <= '0;
         pdata_o   <= '1;
         pmask_o   <= '0;
      end else begin
         prog_o    <= issue;
         seq_err_o <= 1'b0;
         if (!block_i) begin
            exp_q <= '0;
         end else if (wr_i) begin
            if (in_order) begin
               exp_q <= last ? '0 : exp_q + 1'b1;
               if (idx == '0) base_q <= wa;
            end else begin
               exp_q     <= '0;
               seq_err_o <= 1'b1;
            end
         end
         if (issue) begin
            paddr_o <= wa;
            pdata_o <= nxt_data;
            pmask_o <= nxt_mask;
         end
      end
   end

   // R7: a program from block mode covers every lane
   p_block_full_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_o && $past(block_i)) |-> pmask_o == '1);

   // R8: an ordering fault never coincides with a program
   p_seq_err_no_prog_r8: assert property (@(posedge clk) disable iff (!rst_n)
      seq_err_o |-> !prog_o);
endmodule

// File: rtl/kflash_blkwr.sv
module kflash_blkwr
   import kfb_pkg::*;
#(
   parameter int         AW    = 16,
   parameter int         LANES = 4,
   parameter logic [7:0] KEY_A = 8'hA5,
   parameter logic [7:0] KEY_B = 8'hF1,
   localparam int        LW    = $clog2(LANES),
   localparam int        WAW   = AW - LW,
   localparam int        DW    = LANES * 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic             reg_sel,
   input  logic [7:0]       reg_wdata,
   output logic [7:0]       reg_rdata,
   input  logic             xd_wr,
   input  logic             xd_rd,
   input  logic [AW-1:0]    xd_addr,
   input  logic [7:0]       xd_wdata,
   output logic [7:0]       xd_rdata,
   output logic             xd_wait,
   output logic             ram_we,
   output logic             ram_re,
   output logic [AW-1:0]    ram_addr,
   output logic [7:0]       ram_wdata,
   input  logic [7:0]       ram_rdata,
   output logic             fl_prog,
   output logic             fl_erase,
   output logic [WAW-1:0]   fl_addr,
   output logic [DW-1:0]    fl_wdata,
   output logic [LANES-1:0] fl_mask,
   input  logic             fl_busy
);
   logic        route_q, erase_q, block_q, err_q;
   logic        wr_take, to_flash, auth, prog_req, erase_req;
   logic        armed, key_fault, seq_err, key_we;
   key_st_t     kstate;
   logic              bb_prog;
   logic [WAW-1:0]    bb_addr;
   logic [DW-1:0]     bb_data;
   logic [LANES-1:0]  bb_mask;
   logic              ers_q;
   logic [WAW-1:0]    ers_addr_q;

   assign xd_wait   = fl_busy | fl_prog | fl_erase;
   assign wr_take   = xd_wr & ~xd_wait;
   assign to_flash  = wr_take & route_q;
   assign auth      = to_flash & armed;
   assign prog_req  = auth & ~erase_q;
   assign erase_req = auth & erase_q;
   assign key_we    = reg_wr & (reg_sel == SEL_KEY);

   assign ram_we    = wr_take & ~route_q;
   assign ram_re    = xd_rd & ~xd_wait;
   assign ram_addr  = xd_addr;
   assign ram_wdata = xd_wdata;
   assign xd_rdata  = ram_rdata;

   kfb_keyseq #(.KEY_A(KEY_A), .KEY_B(KEY_B)) u_key (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_we   (key_we),
      .key_byte (reg_wdata),
      .use_i    (to_flash),
      .armed_o  (armed),
      .state_o  (kstate),
      .fault_o  (key_fault)
   );

   kfb_blkasm #(.AW(AW), .LANES(LANES)) u_blk (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (prog_req),
      .block_i   (block_q),
      .addr_i    (xd_addr),
      .data_i    (xd_wdata),
      .prog_o    (bb_prog),
      .paddr_o   (bb_addr),
      .pdata_o   (bb_data),
      .pmask_o   (bb_mask),
      .seq_err_o (seq_err)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         route_q <= 1'b0;
         erase_q <= 1'b0;
         block_q <= 1'b0;
      end else if (reg_wr && reg_sel == SEL_CTL) begin
         route_q <= reg_wdata[CTL_ROUTE];
         erase_q <= reg_wdata[CTL_ERASE];
         block_q <= reg_wdata[CTL_BLOCK];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ers_q      <= 1'b0;
         ers_addr_q <= '0;
      end else begin
         ers_q <= erase_req;
         if (erase_req) ers_addr_q <= xd_addr[AW-1:LW];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else if (key_fault || (to_flash && !armed) || seq_err) err_q <= 1'b1;
   end

   assign fl_prog  = bb_prog;
   assign fl_erase = ers_q;
   assign fl_addr  = ers_q ? ers_addr_q : bb_addr;
   assign fl_wdata = bb_data;
   assign fl_mask  = bb_mask;

   always_comb begin
      reg_rdata = '0;
      if (reg_sel == SEL_KEY) begin
         reg_rdata[1:0] = kstate;
      end else begin
         reg_rdata[CTL_ROUTE] = route_q;
         reg_rdata[CTL_ERASE] = erase_q;
         reg_rdata[CTL_BLOCK] = block_q;
         reg_rdata[CTL_ERR]   = err_q;
      end
   end

   // R9: the error flag is sticky
   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   // R10: no command follows a busy cycle
   p_no_cmd_after_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_prog || fl_erase) |-> !$past(fl_busy));

   // R3: a program only follows a write taken while routed to flash
   p_prog_after_flash_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      fl_prog |-> $past(xd_wr && route_q));

   // R5: erase and program never share a cycle
   p_cmd_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_prog && fl_erase));
endmodule

// File: tb/sim_kflash_blkwr.sv
module sim_kflash_blkwr;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0, reg_sel = 1'b0;
   logic [7:0]  reg_wdata = '0, reg_rdata;
   logic        xd_wr = 1'b0, xd_rd = 1'b0;
   logic [15:0] xd_addr = '0;
   logic [7:0]  xd_wdata = '0, xd_rdata;
   logic        xd_wait, ram_we, ram_re;
   logic [15:0] ram_addr;
   logic [7:0]  ram_wdata, ram_rdata;
   logic        fl_prog, fl_erase, fl_busy;
   logic [13:0] fl_addr;
   logic [31:0] fl_wdata;
   logic [3:0]  fl_mask;

   int n_chk = 0, n_bad = 0;
   int n_prog = 0, n_ers = 0, n_ram = 0;
   logic [13:0] last_addr;
   logic [31:0] last_data;
   logic [3:0]  last_mask;
   logic [15:0] last_raddr;
   logic [7:0]  last_rdata;
   int busy_cnt = 0;

   always #4 clk = ~clk;

   kflash_blkwr u0 (.*);

   assign ram_rdata = xd_addr[7:0] ^ 8'h3C;
   assign fl_busy   = (busy_cnt != 0);

   always @(posedge clk) begin
      if (fl_prog || fl_erase) busy_cnt <= 4;
      else if (busy_cnt != 0)  busy_cnt <= busy_cnt - 1;
      if (fl_prog) begin
         n_prog++; last_addr = fl_addr; last_data = fl_wdata; last_mask = fl_mask;
      end
      if (fl_erase) begin
         n_ers++; last_addr = fl_addr;
      end
      if (ram_we) begin
         n_ram++; last_raddr = ram_addr; last_rdata = ram_wdata;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0; xd_wr = 0; xd_rd = 0; reg_wr = 0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      while (fl_busy) @(negedge clk);
   endtask

   task automatic reg_write(input logic sel, input logic [7:0] d);
      @(negedge clk);
      reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic unlock();
      reg_write(1'b0, 8'hA5);
      reg_write(1'b0, 8'hF1);
   endtask

   task automatic cpu_wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      xd_addr = a; xd_wdata = d; xd_wr = 1'b1;
      while (xd_wait) @(negedge clk);
      @(negedge clk);
      xd_wr = 1'b0;
   endtask

   task automatic settle();
      @(negedge clk);
      while (fl_busy) @(negedge clk);
   endtask

   task automatic t_reset();
      do_reset();
      reg_sel = 1'b0; #1;
      chk(reg_rdata == 8'h00, "R11 key state", reg_rdata, 0);
      reg_sel = 1'b1; #1;
      chk(reg_rdata == 8'h00, "R11 control", reg_rdata, 0);
      chk({xd_wait, fl_prog, fl_erase} == 3'b000, "R11 strobes", {xd_wait, fl_prog, fl_erase}, 0);
   endtask

   task automatic t_ram_route();
      int p0;
      do_reset();
      p0 = n_prog;
      cpu_wr(16'h0123, 8'h77);
      @(negedge clk);
      chk(n_ram == 1 && last_raddr == 16'h0123 && last_rdata == 8'h77, "R3 ram write",
          {last_raddr, last_rdata}, {16'h0123, 8'h77});
      chk(n_prog == p0, "R3 no flash", n_prog, p0);
      reg_write(1'b1, 8'h01);
      @(negedge clk);
      xd_rd = 1'b1; xd_addr = 16'h0055; #1;
      chk(ram_re && xd_rdata == 8'h69, "R4 read to ram", {ram_re, xd_rdata}, {1'b1, 8'h69});
      @(negedge clk);
      xd_rd = 1'b0;
   endtask

   task automatic t_single();
      int r0;
      do_reset();
      reg_write(1'b1, 8'h01);
      unlock();
      reg_sel = 1'b0; #1;
      chk(reg_rdata == 8'h02, "R1 armed", reg_rdata, 2);
      r0 = n_ram;
      cpu_wr(16'h1236, 8'h5A);
      chk(xd_wait == 1'b1, "R10 wait after issue", xd_wait, 1);
      settle();
      chk(n_prog == 1, "R6 one program", n_prog, 1);
      chk(last_addr == 14'h048D, "R6 word addr", last_addr, 14'h048D);
      chk(last_mask == 4'b0100, "R6 lane mask", last_mask, 4'b0100);
      chk(last_data == 32'hFF5AFFFF, "R6 lane data", last_data, 32'hFF5AFFFF);
      chk(n_ram == r0, "R3 not to ram", n_ram, r0);
      reg_sel = 1'b0; #1;
      chk(reg_rdata == 8'h00, "R1 consumed", reg_rdata, 0);
      cpu_wr(16'h1237, 8'h11);
      settle();
      chk(n_prog == 1, "R9 no program without key", n_prog, 1);
      reg_sel = 1'b1; #1;
      chk(reg_rdata[7] == 1'b1, "R9 error flag", reg_rdata[7], 1);
   endtask

   task automatic t_erase();
      int p0;
      do_reset();
      p0 = n_prog;
      reg_write(1'b1, 8'h03);
      unlock();
      cpu_wr(16'h4004, 8'h00);
      settle();
      chk(n_ers == 1 && last_addr == 14'h1001, "R5 erase", {n_ers[3:0], last_addr}, {4'd1, 14'h1001});
      chk(n_prog == p0, "R5 no program", n_prog, p0);
   endtask

   task automatic t_block();
      int p0;
      do_reset();
      p0 = n_prog;
      reg_write(1'b1, 8'h05);
      for (int i = 0; i < 3; i++) begin
         unlock();
         cpu_wr(16'h2000 + 16'(i), 8'(8'h11 * (i + 1)));
      end
      settle();
      chk(n_prog == p0, "R7 nothing before last byte", n_prog, p0);
      unlock();
      cpu_wr(16'h2003, 8'h44);
      settle();
      chk(n_prog == p0 + 1, "R7 one program", n_prog, p0 + 1);
      chk(last_data == 32'h44332211, "R7 block data", last_data, 32'h44332211);
      chk(last_mask == 4'hF && last_addr == 14'h0800, "R7 mask addr",
          {last_mask, last_addr}, {4'hF, 14'h0800});
      reg_sel = 1'b1; #1;
      chk(reg_rdata[7] == 1'b0, "R7 no error", reg_rdata[7], 0);
      p0 = n_prog;
      unlock(); cpu_wr(16'h3000, 8'hAA);
      unlock(); cpu_wr(16'h3002, 8'hBB);
      unlock(); cpu_wr(16'h3003, 8'hCC);
      settle();
      chk(n_prog == p0, "R8 discarded", n_prog, p0);
      reg_sel = 1'b1; #1;
      chk(reg_rdata[7] == 1'b1, "R8 error flag", reg_rdata[7], 1);
   endtask

   task automatic t_stall();
      int r0, hold;
      do_reset();
      reg_write(1'b1, 8'h01);
      unlock();
      cpu_wr(16'h0010, 8'h01);
      reg_sel = 1'b1; reg_wdata = 8'h00; reg_wr = 1'b1;
      r0 = n_ram;
      @(negedge clk);
      reg_wr = 1'b0;
      xd_addr = 16'h0099; xd_wdata = 8'h3E; xd_wr = 1'b1;
      hold = 0;
      while (xd_wait) begin
         #1;
         if (ram_we) hold++;
         @(negedge clk);
      end
      chk(hold == 0 && n_ram == r0, "R10 write held", hold, 0);
      @(negedge clk);
      xd_wr = 1'b0;
      @(negedge clk);
      chk(n_ram == r0 + 1 && last_raddr == 16'h0099, "R10 write after busy",
          {n_ram[7:0], last_raddr}, {8'(r0 + 1), 16'h0099});
   endtask

   task automatic t_lock();
      int p0;
      do_reset();
      reg_write(1'b0, 8'hF1);
      reg_sel = 1'b0; #1;
      chk(reg_rdata == 8'h03, "R2 locked", reg_rdata, 3);
      reg_sel = 1'b1; #1;
      chk(reg_rdata[7] == 1'b1, "R2 error flag", reg_rdata[7], 1);
      unlock();
      reg_sel = 1'b0; #1;
      chk(reg_rdata == 8'h03, "R2 stays locked", reg_rdata, 3);
      p0 = n_prog;
      reg_write(1'b1, 8'h01);
      cpu_wr(16'h0040, 8'h12);
      settle();
      chk(n_prog == p0, "R2 no program while locked", n_prog, p0);
      do_reset();
      reg_write(1'b0, 8'hA5);
      reg_write(1'b0, 8'hA5);
      reg_sel = 1'b0; #1;
      chk(reg_rdata == 8'h03, "R2 wrong second key", reg_rdata, 3);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_ram_route();
      t_single();
      t_erase();
      t_block();
      t_stall();
      t_lock();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule